// File: doc/BRIEF.md
# SDRAM Clock-Enable Power State Tracker

This block follows the low-power behaviour that an SDRAM device derives from its clock-enable input. On every rising clock edge it looks at the clock-enable level of the previous cycle, the level in the current cycle, and the command on the chip-select, row-strobe, column-strobe and write-enable lines. From these it decides whether the device runs normally, suspends its internal clock, enters or leaves power-down, or enters or leaves self-refresh.

Bank state is not tracked here. An external all-banks-idle signal tells the tracker whether a falling clock-enable may start a low-power mode or only suspends the clock. The outputs are the registered power state, an internal clock-enable indication, a flag that the present command is taken as a normal operation, and a one-cycle flag for forbidden clock-enable and command combinations.

Top module: `sdram_cke_tracker`

## Requirements
- R1: After reset the state is RUN (code 0), `clk_en_o` is 1, `illegal_o` is 0 and the stored previous clock-enable is high, so a high `cke` in the first cycle gives `cmd_accept_o` = 1.
- R2: In RUN or SUSPEND with `all_idle` = 1, previous `cke` high and current `cke` low, a NOP (cs_n=0, ras_n=cas_n=we_n=1) or a deselect (cs_n=1) moves the state to PWRDN (code 2) after the edge.
- R3: Under the same conditions an auto-refresh command (cs_n=ras_n=cas_n=0, we_n=1) moves the state to SELFREF (code 3).
- R4: Under the same conditions any other command sets `illegal_o` for the next cycle and leaves the state unchanged.
- R5: With `all_idle` = 0, a high-to-low `cke` moves RUN to SUSPEND (code 1) whatever the command; a low-power state is never entered without `all_idle` high at the deciding edge.
- R6: In PWRDN or SELFREF, previous and current `cke` both low keeps the state.
- R7: In PWRDN or SELFREF, a low-to-high `cke` with NOP or deselect returns to RUN; with any other command it sets `illegal_o` and keeps the state.
- R8: In PWRDN or SELFREF, a sample with previous `cke` high is invalid: `illegal_o` is set and the state is kept.
- R9: In RUN or SUSPEND outside the entry cases, low-to-high `cke` gives RUN and low-low gives SUSPEND from the next cycle; high-high keeps RUN.
- R10: `clk_en_o` is 1 exactly when the state is RUN; `cmd_accept_o` is 1 when the state is RUN and both previous and current `cke` are high.
- R11: `illegal_o` is a registered flag lasting one cycle per forbidden sample, 0 after every legal sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cke | input | 1 | Clock-enable level of the current cycle |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| all_idle | input | 1 | All banks idle, from the bank controller |
| state_o | output | 2 | Power state: 0 RUN, 1 SUSPEND, 2 PWRDN, 3 SELFREF |
| clk_en_o | output | 1 | Internal clock enabled |
| cmd_accept_o | output | 1 | Current command is taken as a normal operation |
| illegal_o | output | 1 | Previous sample was a forbidden combination |

## Verification
The interesting collisions are a forbidden command and a state hold in the same cycle: an exit attempt with a read command inside power-down must flag and stay, and the very next sample, now seeing previous `cke` high, must flag again as invalid while still staying. A second overlap is the idle input toggling on the exact edge where `cke` falls, which decides between suspend and a low-power entry. Both are provoked by directed sequences, and every cycle the outputs are compared against a behavioural model in the bench that replays the same inputs.

// File: rtl/sdram_cke_pkg.sv
package sdram_cke_pkg;

  localparam int unsigned STATE_W = 2;

  typedef enum logic [STATE_W-1:0] {
    PST_RUN     = 2'd0,
    PST_SUSPEND = 2'd1,
    PST_PWRDN   = 2'd2,
    PST_SELFREF = 2'd3
  } pwr_state_e;

  typedef enum logic [1:0] {
    CMDC_QUIET   = 2'd0,
    CMDC_REFRESH = 2'd1,
    CMDC_OTHER   = 2'd2
  } cmd_class_e;

  // deselect or NOP are both quiet
  function automatic cmd_class_e classify_cmd(input logic cs_n, input logic ras_n,
                                              input logic cas_n, input logic we_n);
    if (cs_n) return CMDC_QUIET;
    if (ras_n && cas_n && we_n) return CMDC_QUIET;
    if (!ras_n && !cas_n && we_n) return CMDC_REFRESH;
    return CMDC_OTHER;
  endfunction

  function automatic logic is_low_power(input pwr_state_e s);
    return (s == PST_PWRDN) || (s == PST_SELFREF);
  endfunction

endpackage

// File: rtl/cke_history.sv
module cke_history #(
  parameter logic RESET_LEVEL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cke,
  output logic cke_prev
);
  always_ff @(posedge clk) begin
    if (!rst_n) cke_prev <= RESET_LEVEL;
    else        cke_prev <= cke;
  end
endmodule

// File: rtl/cmd_classifier.sv
module cmd_classifier
  import sdram_cke_pkg::*;
(
  input  logic       cs_n,
  input  logic       ras_n,
  input  logic       cas_n,
  input  logic       we_n,
  output cmd_class_e cls
);
  always_comb cls = classify_cmd(cs_n, ras_n, cas_n, we_n);
endmodule

// File: rtl/power_fsm.sv
module power_fsm
  import sdram_cke_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cke,
  input  logic       cke_prev,
  input  cmd_class_e cls,
  input  logic       all_idle,
  output pwr_state_e state,
  output logic       illegal,
  output logic       bad_now
);
  pwr_state_e nxt;

  always_comb begin
    nxt     = state;
    bad_now = 1'b0;
    if (is_low_power(state)) begin
      if (cke_prev) begin
        bad_now = 1'b1;               // invalid sample
      end else if (cke) begin
        if (cls == CMDC_QUIET) nxt = PST_RUN;
        else                   bad_now = 1'b1;
      end
    end else begin
      unique case ({cke_prev, cke})
        2'b10: begin
          if (all_idle) begin
            if (cls == CMDC_QUIET)        nxt = PST_PWRDN;
            else if (cls == CMDC_REFRESH) nxt = PST_SELFREF;
            else                          bad_now = 1'b1;
          end else begin
            nxt = PST_SUSPEND;
          end
        end
        2'b01:   nxt = PST_RUN;
        2'b00:   nxt = PST_SUSPEND;
        default: nxt = PST_RUN;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= PST_RUN;
      illegal <= 1'b0;
    end else begin
      state   <= nxt;
      illegal <= bad_now;
    end
  end
endmodule

// File: rtl/sdram_cke_tracker.sv
module sdram_cke_tracker
  import sdram_cke_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cke,
  input  logic               cs_n,
  input  logic               ras_n,
  input  logic               cas_n,
  input  logic               we_n,
  input  logic               all_idle,
  output logic [STATE_W-1:0] state_o,
  output logic               clk_en_o,
  output logic               cmd_accept_o,
  output logic               illegal_o
);
  logic       cke_prev_w;
  cmd_class_e cls_w;
  pwr_state_e state_w;
  logic       bad_now_w;

  cke_history #(.RESET_LEVEL(1'b1)) u_hist (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cke_prev(cke_prev_w)
  );

  cmd_classifier u_cls (
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .cls(cls_w)
  );

  power_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cke_prev(cke_prev_w), .cls(cls_w),
    .all_idle(all_idle), .state(state_w), .illegal(illegal_o), .bad_now(bad_now_w)
  );

  assign state_o      = state_w;
  assign clk_en_o     = (state_w == PST_RUN);
  assign cmd_accept_o = clk_en_o && cke_prev_w && cke;
endmodule

// File: rtl/sdram_cke_tracker_chk.sv
module sdram_cke_tracker_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cke,
  input logic       cke_prev,
  input logic       cs_n,
  input logic       ras_n,
  input logic       cas_n,
  input logic       we_n,
  input logic       all_idle,
  input logic [1:0] state_o,
  input logic       illegal_o
);
  logic lp, quiet;
  assign lp    = state_o[1];
  assign quiet = cs_n || (ras_n && cas_n && we_n);

  assert_entry_needs_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !lp |=> (!lp || $past(all_idle)));

  assert_busy_fall_suspends_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!lp && cke_prev && !cke && !all_idle) |=> (state_o == 2'd1));

  assert_low_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (lp && !cke) |=> $stable(state_o));

  assert_bad_exit_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (lp && !cke_prev && cke && !quiet) |=> (illegal_o && $stable(state_o)));

  assert_invalid_sample_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (lp && cke_prev) |=> (illegal_o && $stable(state_o)));

  assert_lp_leaves_to_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
    lp |=> (lp || state_o == 2'd0));
endmodule

bind sdram_cke_tracker sdram_cke_tracker_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cke(cke), .cke_prev(cke_prev_w),
  .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
  .all_idle(all_idle), .state_o(state_o), .illegal_o(illegal_o)
);

// File: tb/sdram_cke_tracker_test.sv
module sdram_cke_tracker_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n, cke, cs_n, ras_n, cas_n, we_n, all_idle;
  logic [1:0] state_o;
  logic clk_en_o, cmd_accept_o, illegal_o;

  int tests = 0, fails = 0;
  string req = "R1";

  // model variables
  int m_state = 0;
  bit m_prev = 1'b1, m_ill = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_cke_tracker uut (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .all_idle(all_idle), .state_o(state_o),
    .clk_en_o(clk_en_o), .cmd_accept_o(cmd_accept_o), .illegal_o(illegal_o)
  );

  task automatic check(input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // command codes: 0 NOP, 1 deselect, 2 refresh, 3 read
  task automatic set_cmd(input int c);
    case (c)
      0: {cs_n, ras_n, cas_n, we_n} = 4'b0111;
      1: {cs_n, ras_n, cas_n, we_n} = 4'b1111;
      2: {cs_n, ras_n, cas_n, we_n} = 4'b0001;
      default: {cs_n, ras_n, cas_n, we_n} = 4'b0101;
    endcase
  endtask

  task automatic step(input bit k, input int c, input bit idle);
    bit quiet, lp;
    int nxt;
    bit bad;
    @(negedge clk);
    cke = k; set_cmd(c); all_idle = idle;
    #1;
    check("state", state_o, m_state);
    check("clk_en", clk_en_o, m_state == 0);
    check("illegal", illegal_o, m_ill);
    check("accept", cmd_accept_o, (m_state == 0) && m_prev && k);
    quiet = (c == 0) || (c == 1);
    lp = (m_state >= 2);
    nxt = m_state; bad = 0;
    if (lp) begin
      if (m_prev) bad = 1;
      else if (k) begin if (quiet) nxt = 0; else bad = 1; end
    end else if (m_prev && !k) begin
      if (!idle) nxt = 1;
      else if (quiet) nxt = 2;
      else if (c == 2) nxt = 3;
      else bad = 1;
    end else nxt = k ? 0 : 1;
    @(posedge clk);
    m_state = nxt; m_ill = bad; m_prev = k;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++; tests++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cke = 1'b1; set_cmd(0); all_idle = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    req = "R1";  step(1, 0, 1); step(1, 3, 1);
    req = "R2";  step(0, 0, 1); step(0, 0, 1);
    req = "R6";  step(0, 3, 0); step(0, 2, 1);
    req = "R7";  step(1, 1, 1); step(1, 0, 1);
    req = "R2";  step(0, 1, 1); step(0, 0, 1);
    req = "R7";  step(1, 3, 1);
    req = "R8";  step(1, 0, 1); step(0, 0, 1); step(0, 0, 1);
    req = "R7";  step(1, 0, 1); step(1, 0, 1);
    req = "R3";  step(0, 2, 1); step(0, 0, 1); step(0, 3, 1);
    req = "R8";  step(1, 3, 1); step(1, 0, 1); step(0, 1, 1);
    req = "R7";  step(1, 1, 1); step(1, 0, 1);
    req = "R4";  step(0, 3, 1); step(0, 0, 1); step(1, 0, 1); step(1, 0, 1);
    req = "R5";  step(0, 2, 0); step(0, 0, 1); step(0, 2, 1);
    req = "R9";  step(1, 3, 0); step(1, 0, 1); step(0, 0, 0); step(1, 0, 1);
    req = "R10"; step(1, 3, 0); step(0, 3, 0); step(1, 3, 0); step(1, 3, 0);
    req = "R11"; step(0, 3, 1); step(0, 0, 0); step(1, 0, 0); step(1, 0, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule